// File: doc/BRIEF.md
# Receive Frame Forwarding Gate

This block sits between a receive MAC and its DMA engine. It stores arriving frames one byte at a time and decides, frame by frame, when bytes may be handed to the reader. In cut-through operation a frame opens to the reader once its filter verdict is a pass and enough of its bytes are stored. In store-and-forward operation a frame opens only when its last byte is in. Frames that fail the filter are removed. Frames cut short by a collision before reaching the minimum length are removed as well. Frames that are removed have their space returned by rolling the write pointer back to the frame's first byte.

The write side is the state machine `rxg_wr_ctl`. Its states are W_IDLE (between frames), W_HOLD (frame open but not yet visible), W_PASS (frame visible and still arriving) and W_SKIP (the rest of a dropped or truncated frame is ignored). It moves as follows:
- W_IDLE to W_HOLD or W_PASS on a start byte.
- W_HOLD to W_PASS when the threshold is crossed.
- W_HOLD or W_PASS to W_IDLE on the last byte or on an abort.
- W_HOLD to W_SKIP on a filter failure in mid-frame.
- W_HOLD or W_PASS to W_SKIP when the storage runs out.
- W_SKIP to W_IDLE on the end or abort of the ignored frame.

The read side `rxg_rd_ctl` has two states. R_RUN presents bytes. R_FLUSH discards the head frame. It goes from R_RUN to R_FLUSH on an accepted flush, and from R_FLUSH back to R_RUN after the discarded frame's last byte.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset, rd_valid is low and stays low until a frame is made visible.
- R2: With cfg_store_fwd=0 and cfg_thr_sel=0, the first byte of a filter-passed frame is offered (rd_valid=1) in the cycle after its 64th byte is written. After the 63rd byte it is not yet offered.
- R3: cfg_thr_sel selects the cut-through threshold: 1 gives 32 bytes, 2 gives 96 bytes and 3 gives 128 bytes. Each is checked like R2.
- R4: With cfg_store_fwd=1, no byte of a frame is offered before the byte carrying wr_eof has been written.
- R5: A frame that receives wr_filt_valid=1 with wr_filt_pass=0 is removed and never offered. A frame whose last byte passes with no filter result is also removed.
- R6: With cfg_rx_all=1, a frame that fails the filter is kept and delivered intact.
- R7: An abort (wr_abort=1) on a frame not yet visible with fewer than 64 bytes purges it. An abort on a visible frame appends a byte with data 0x00, rd_eof=1 and rd_err=1.
- R8: rd_flush, while at least one complete frame is stored, discards the rest of the head frame, and the next frame follows. A flush with no complete frame stored has no effect.
- R9: When a byte takes the last free storage slot mid-frame, it is stored with rd_eof=1 and rd_err=1, and the frame becomes visible. Later bytes of that frame are ignored until its end, and the next frame is received normally.
- R10: Bytes leave in write order, with rd_sof on the first byte of each frame and rd_eof on its last. rd_data is held while rd_valid=1 and rd_ready=0. rd_err=1 only together with rd_eof=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_store_fwd | input | 1 | 1: release frames only when complete |
| cfg_thr_sel | input | 2 | Cut-through threshold code (0:64, 1:32, 2:96, 3:128) |
| cfg_rx_all | input | 1 | Keep frames that fail the filter |
| wr_valid | input | 1 | A received byte is present |
| wr_data | input | 8 | Received byte |
| wr_sof | input | 1 | Byte is the first of a frame |
| wr_eof | input | 1 | Byte is the last of a frame |
| wr_abort | input | 1 | Frame ended early (collision or cut short), carries no byte |
| wr_filt_valid | input | 1 | Address filter verdict is present this cycle |
| wr_filt_pass | input | 1 | Filter verdict: 1 pass, 0 fail |
| rd_valid | output | 1 | A byte is offered to the reader |
| rd_ready | input | 1 | Reader takes the offered byte |
| rd_data | output | 8 | Offered byte |
| rd_sof | output | 1 | Offered byte starts a frame |
| rd_eof | output | 1 | Offered byte ends a frame |
| rd_err | output | 1 | Frame ended by abort or truncation |
| rd_flush | input | 1 | Discard the head frame |

## Verification
The bench probes the exact byte at which each threshold code opens a frame. A design off by one would offer data one byte early or late. In store-and-forward mode it checks the byte before the end, where a leaky design would already show data. It sends dropped frames (filter fail, missing verdict, short abort) followed by good frames. A design that forgets to roll back its write pointer would then deliver stale bytes into the scoreboard. Further tests cover an abort after release, a flush of the head frame with a second frame behind it, a flush on an empty store, and a frame long enough to fill the whole store. These catch a missing terminator byte, a flush that eats the wrong frame, and a truncation that loses the error mark.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    typedef enum logic [1:0] {W_IDLE, W_HOLD, W_PASS, W_SKIP} wr_state_t;
    typedef enum logic       {R_RUN, R_FLUSH} rd_state_t;

    typedef struct packed {
        logic       err;
        logic       eof;
        logic [7:0] data;
    } cell_t;

    // threshold in bytes for a selection code, built from a base unit
    function automatic int unsigned thr_bytes(logic [1:0] sel, int unsigned unit);
        case (sel)
            2'd0:    return 2 * unit;
            2'd1:    return unit;
            2'd2:    return 3 * unit;
            default: return 4 * unit;
        endcase
    endfunction

endpackage

// File: rtl/rxg_store.sv
module rxg_store #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  rxg_pkg::cell_t  wcell,
    input  logic [AW-1:0]   raddr,
    output rxg_pkg::cell_t  rcell
);
    rxg_pkg::cell_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wcell;
    end

    assign rcell = mem[raddr];
endmodule

// File: rtl/rxg_wr_ctl.sv
module rxg_wr_ctl
    import rxg_pkg::*;
#(
    parameter int unsigned DEPTH    = 2048,
    parameter int unsigned THR_UNIT = 32,
    parameter int unsigned RUNT_LEN = 64,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned PW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_store_fwd,
    input  logic [1:0]    cfg_thr_sel,
    input  logic          cfg_rx_all,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_sof,
    input  logic          wr_eof,
    input  logic          wr_abort,
    input  logic          wr_filt_valid,
    input  logic          wr_filt_pass,
    input  logic [PW-1:0] rd_ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output cell_t         mem_wcell,
    output logic [PW-1:0] vis_ptr,
    output logic          frame_done
);
    localparam logic [PW-1:0] FULL_W = PW'(DEPTH);
    localparam logic [PW-1:0] LAST_W = PW'(DEPTH - 1);
    localparam logic [PW-1:0] RUNT_W = PW'(RUNT_LEN);

    wr_state_t     state, st_n;
    logic [PW-1:0] wptr, wptr_n, fs_ptr, fs_n, fcnt, fcnt_n, cnt_nx, occ, thr_w;
    logic          pass_seen, pass_n, pass_now, fail_now;
    logic          has_room, last_slot, released, take, drop, close;

    assign occ       = wptr - rd_ptr;
    assign has_room  = (occ != FULL_W);
    assign last_slot = (occ == LAST_W);
    assign thr_w     = PW'(thr_bytes(cfg_thr_sel, THR_UNIT));
    assign pass_now  = pass_seen | (wr_filt_valid & (wr_filt_pass | cfg_rx_all));
    assign fail_now  = wr_filt_valid & ~wr_filt_pass & ~cfg_rx_all;
    assign released  = (state == W_PASS);
    assign cnt_nx    = ((state == W_IDLE) ? '0 : fcnt) + PW'(1);
    assign vis_ptr   = released ? wptr : fs_ptr;
    assign mem_waddr = wptr[AW-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= W_IDLE;
            wptr      <= '0;
            fs_ptr    <= '0;
            fcnt      <= '0;
            pass_seen <= 1'b0;
        end else begin
            state     <= st_n;
            wptr      <= wptr_n;
            fs_ptr    <= fs_n;
            fcnt      <= fcnt_n;
            pass_seen <= pass_n;
        end
    end

    // transitions and outputs
    always_comb begin
        st_n       = state;
        wptr_n     = wptr;
        fs_n       = fs_ptr;
        fcnt_n     = fcnt;
        pass_n     = pass_now;
        take       = 1'b0;
        drop       = 1'b0;
        close      = 1'b0;
        mem_we     = 1'b0;
        mem_wcell  = '0;
        frame_done = 1'b0;
        unique case (state)
            W_IDLE: begin
                fcnt_n = '0;
                if (wr_valid && wr_sof) begin
                    if (!has_room || fail_now) st_n = wr_eof ? W_IDLE : W_SKIP;
                    else                       take = 1'b1;
                end
            end
            W_HOLD, W_PASS: begin
                if (wr_abort) begin
                    st_n = W_IDLE;
                    if (!released && (fcnt < RUNT_W || !pass_seen)) begin
                        drop = 1'b1;
                    end else begin
                        mem_we    = 1'b1;
                        mem_wcell = '{err: 1'b1, eof: 1'b1, data: 8'h00};
                        wptr_n    = wptr + PW'(1);
                        close     = 1'b1;
                    end
                end else if (!released && fail_now) begin
                    drop = 1'b1;
                    st_n = (wr_valid && wr_eof) ? W_IDLE : W_SKIP;
                end else if (wr_valid) begin
                    take = 1'b1;
                end
            end
            W_SKIP: begin
                if (wr_abort || (wr_valid && wr_eof)) st_n = W_IDLE;
            end
        endcase

        if (take) begin
            mem_we         = 1'b1;
            mem_wcell.data = wr_data;
            mem_wcell.eof  = wr_eof | last_slot;
            mem_wcell.err  = last_slot & ~wr_eof;
            wptr_n         = wptr + PW'(1);
            fcnt_n         = cnt_nx;
            if (wr_eof || last_slot) begin
                if (!released && !pass_now) drop = 1'b1;
                else                        close = 1'b1;
                st_n = wr_eof ? W_IDLE : W_SKIP;
            end else if (released || (!cfg_store_fwd && pass_now && cnt_nx >= thr_w)) begin
                st_n = W_PASS;
            end else begin
                st_n = W_HOLD;
            end
        end

        if (drop) begin
            mem_we = 1'b0;
            wptr_n = fs_ptr;
        end
        if (close) begin
            fs_n       = wptr_n;
            frame_done = 1'b1;
        end
        if (st_n == W_IDLE || st_n == W_SKIP) begin
            pass_n = 1'b0;
            fcnt_n = '0;
        end
    end
endmodule

// File: rtl/rxg_rd_ctl.sv
module rxg_rd_ctl
    import rxg_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] vis_ptr,
    input  logic          frame_done,
    input  cell_t         rcell,
    input  logic          rd_ready,
    input  logic          rd_flush,
    output logic [PW-1:0] rd_ptr,
    output logic [AW-1:0] raddr,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          rd_sof,
    output logic          rd_eof,
    output logic          rd_err
);
    rd_state_t     rstate, rs_n;
    logic [PW-1:0] nfrm, nfrm_n, rptr_n;
    logic          at_sof, sof_n, avail, pop, fstep, eof_out, flush_go;

    assign avail    = (rd_ptr != vis_ptr);
    assign flush_go = (rstate == R_RUN) && rd_flush && (nfrm != '0);
    assign pop      = (rstate == R_RUN) && avail && rd_ready && !flush_go;
    assign fstep    = (rstate == R_FLUSH) && avail;
    assign eof_out  = (pop || fstep) && rcell.eof;
    assign raddr    = rd_ptr[AW-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rstate <= R_RUN;
            rd_ptr <= '0;
            nfrm   <= '0;
            at_sof <= 1'b1;
        end else begin
            rstate <= rs_n;
            rd_ptr <= rptr_n;
            nfrm   <= nfrm_n;
            at_sof <= sof_n;
        end
    end

    // transitions
    always_comb begin
        rs_n   = rstate;
        rptr_n = (pop || fstep) ? rd_ptr + PW'(1) : rd_ptr;
        nfrm_n = nfrm + PW'(frame_done) - PW'(eof_out);
        sof_n  = eof_out ? 1'b1 : (pop ? 1'b0 : at_sof);
        unique case (rstate)
            R_RUN:   if (flush_go) rs_n = R_FLUSH;
            R_FLUSH: if (eof_out)  rs_n = R_RUN;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = (rstate == R_RUN) && avail;
        rd_data  = rcell.data;
        rd_sof   = at_sof;
        rd_eof   = rcell.eof;
        rd_err   = rcell.err;
    end
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
    parameter int unsigned DEPTH    = 2048,
    parameter int unsigned THR_UNIT = 32,
    parameter int unsigned RUNT_LEN = 64,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned PW      = AW + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_store_fwd,
    input  logic [1:0] cfg_thr_sel,
    input  logic       cfg_rx_all,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_sof,
    input  logic       wr_eof,
    input  logic       wr_abort,
    input  logic       wr_filt_valid,
    input  logic       wr_filt_pass,
    output logic       rd_valid,
    input  logic       rd_ready,
    output logic [7:0] rd_data,
    output logic       rd_sof,
    output logic       rd_eof,
    output logic       rd_err,
    input  logic       rd_flush
);
    logic           mem_we, frame_done;
    logic [AW-1:0]  mem_waddr, raddr;
    logic [PW-1:0]  vis_ptr, rd_ptr;
    rxg_pkg::cell_t mem_wcell, rcell;

    rxg_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wcell(mem_wcell),
        .raddr(raddr), .rcell(rcell)
    );

    rxg_wr_ctl #(.DEPTH(DEPTH), .THR_UNIT(THR_UNIT), .RUNT_LEN(RUNT_LEN)) wr_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_store_fwd(cfg_store_fwd), .cfg_thr_sel(cfg_thr_sel), .cfg_rx_all(cfg_rx_all),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .wr_abort(wr_abort), .wr_filt_valid(wr_filt_valid), .wr_filt_pass(wr_filt_pass),
        .rd_ptr(rd_ptr), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wcell(mem_wcell),
        .vis_ptr(vis_ptr), .frame_done(frame_done)
    );

    rxg_rd_ctl #(.DEPTH(DEPTH)) rd_i (
        .clk(clk), .rst_n(rst_n), .vis_ptr(vis_ptr), .frame_done(frame_done),
        .rcell(rcell), .rd_ready(rd_ready), .rd_flush(rd_flush),
        .rd_ptr(rd_ptr), .raddr(raddr), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_err(rd_err)
    );
endmodule

// File: rtl/rxg_checker.sv
module rxg_checker #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned PW    = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          rd_flush,
    input logic [7:0]    rd_data,
    input logic          rd_eof,
    input logic          rd_err,
    input logic [PW-1:0] vis_ptr,
    input logic [PW-1:0] rd_ptr
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_valid);

    a_r10_err_with_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_err) |-> rd_eof);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !rd_flush) |=> (rd_valid && $stable(rd_data)));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (vis_ptr - rd_ptr) <= PW'(DEPTH));
endmodule

bind rx_frame_gate rxg_checker #(.DEPTH(DEPTH), .PW(PW)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_flush(rd_flush), .rd_data(rd_data), .rd_eof(rd_eof), .rd_err(rd_err),
    .vis_ptr(vis_ptr), .rd_ptr(rd_ptr)
);

// File: tb/rx_frame_gate_tb_top.sv
`timescale 1ns/1ps
module rx_frame_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_store_fwd = 1'b0, cfg_rx_all = 1'b0;
    logic [1:0] cfg_thr_sel = 2'd0;
    logic       wr_valid = 0, wr_sof = 0, wr_eof = 0, wr_abort = 0;
    logic       wr_filt_valid = 0, wr_filt_pass = 0;
    logic [7:0] wr_data = '0;
    logic       rd_ready = 0, rd_flush = 0;
    logic       rd_valid, rd_sof, rd_eof, rd_err;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [10:0] expq[$];   // {sof, eof, err, data}

    always #2 clk = ~clk;

    rx_frame_gate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_store_fwd(cfg_store_fwd), .cfg_thr_sel(cfg_thr_sel),
        .cfg_rx_all(cfg_rx_all), .wr_valid(wr_valid), .wr_data(wr_data), .wr_sof(wr_sof),
        .wr_eof(wr_eof), .wr_abort(wr_abort), .wr_filt_valid(wr_filt_valid),
        .wr_filt_pass(wr_filt_pass), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_err(rd_err),
        .rd_flush(rd_flush)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            if (expq.size() == 0) begin
                chk(0, "R10 unexpected byte", {rd_sof, rd_eof, rd_err, rd_data}, 0);
            end else begin
                logic [10:0] e;
                e = expq.pop_front();
                chk({rd_sof, rd_eof, rd_err, rd_data} == e, "R10 byte/marks",
                    {rd_sof, rd_eof, rd_err, rd_data}, e);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic put_byte(input logic [7:0] d, input bit s, input bit e, input bit fv, input bit fp);
        wr_valid = 1; wr_data = d; wr_sof = s; wr_eof = e; wr_filt_valid = fv; wr_filt_pass = fp;
        step();
        wr_valid = 0; wr_sof = 0; wr_eof = 0; wr_filt_valid = 0; wr_filt_pass = 0;
    endtask

    task automatic abort_pulse();
        wr_abort = 1; step(); wr_abort = 0;
    endtask

    // driver: sends a frame, pushes expected bytes when the frame should emerge
    task automatic frame(input int len, input int seed, input int fidx, input bit fp,
                         input bit expect_out, input bit with_eof);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = 8'(seed + i);
            if (expect_out) expq.push_back({i == 0, with_eof && i == len - 1, 1'b0, d});
            put_byte(d, i == 0, with_eof && i == len - 1, i == fidx, fp);
        end
    endtask

    // threshold probe: check rd_valid just before and at the opening byte
    task automatic gate_probe(input int len, input int open_at, input int seed, input string tag);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = 8'(seed + i);
            expq.push_back({i == 0, i == len - 1, 1'b0, d});
            put_byte(d, i == 0, i == len - 1, i == 0, 1'b1);
            if (i + 1 == open_at - 1) chk(rd_valid == 0, {tag, " closed before"}, rd_valid, 0);
            if (i + 1 == open_at)     chk(rd_valid == 1, {tag, " open at"}, rd_valid, 1);
        end
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        rd_ready = 1;
        while ((expq.size() != 0 || rd_valid) && guard < 6000) begin
            step(); guard++;
        end
        rd_ready = 0;
        chk(expq.size() == 0, {tag, " all expected bytes delivered"}, expq.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk(rd_valid == 0, "R1 idle after reset", rd_valid, 0);

        // R2: default 64-byte threshold
        gate_probe(100, 64, 8'h10, "R2");
        drain("R2");

        // R3: other threshold codes
        cfg_thr_sel = 2'd1; gate_probe(80, 32, 8'h20, "R3 sel1");  drain("R3");
        cfg_thr_sel = 2'd2; gate_probe(150, 96, 8'h30, "R3 sel2"); drain("R3");
        cfg_thr_sel = 2'd3; gate_probe(150, 128, 8'h40, "R3 sel3"); drain("R3");
        cfg_thr_sel = 2'd0;

        // R4: store-and-forward opens only at the end
        cfg_store_fwd = 1;
        gate_probe(100, 100, 8'h50, "R4");
        drain("R4");
        cfg_store_fwd = 0;

        // R5: filter fail and missing verdict both remove the frame
        frame(90, 8'h60, 10, 1'b0, 1'b0, 1'b1);
        chk(rd_valid == 0, "R5 failed frame hidden", rd_valid, 0);
        frame(80, 8'h70, -1, 1'b0, 1'b0, 1'b1);
        chk(rd_valid == 0, "R5 no-verdict frame hidden", rd_valid, 0);
        frame(70, 8'h80, 3, 1'b1, 1'b1, 1'b1);
        drain("R5");

        // R6: receive-all keeps a failed frame
        cfg_rx_all = 1;
        frame(75, 8'h90, 5, 1'b0, 1'b1, 1'b1);
        drain("R6");
        cfg_rx_all = 0;

        // R7: short abort purges, abort after release appends error terminator
        frame(40, 8'hA0, 0, 1'b1, 1'b0, 1'b0);
        abort_pulse();
        chk(rd_valid == 0, "R7 runt purged", rd_valid, 0);
        frame(66, 8'hB0, 0, 1'b1, 1'b1, 1'b1);
        drain("R7 after runt");
        cfg_thr_sel = 2'd1;
        frame(50, 8'hC0, 0, 1'b1, 1'b1, 1'b0);
        expq.push_back({1'b0, 1'b1, 1'b1, 8'h00});
        abort_pulse();
        drain("R7 released abort");
        cfg_thr_sel = 2'd0;

        // R8: flush on empty store has no effect; flush drops head frame only
        rd_flush = 1; step(); rd_flush = 0;
        frame(20, 8'hD0, 0, 1'b1, 1'b0, 1'b1);
        frame(30, 8'hE0, 0, 1'b1, 1'b1, 1'b1);
        chk(rd_valid == 1 && rd_data == 8'hD0, "R8 head frame present", rd_data, 8'hD0);
        rd_flush = 1; step(); rd_flush = 0;
        repeat (25) step();
        chk(rd_valid == 1 && rd_data == 8'hE0 && rd_sof == 1, "R8 second frame after flush",
            rd_data, 8'hE0);
        drain("R8");
        frame(12, 8'hF0, 0, 1'b1, 1'b1, 1'b1);
        drain("R8 after flushes");

        // R10: data held while reader stalls
        frame(70, 8'h11, 0, 1'b1, 1'b1, 1'b1);
        begin
            logic [7:0] held;
            held = rd_data;
            repeat (3) step();
            chk(rd_valid == 1 && rd_data == held, "R10 held while stalled", rd_data, held);
        end
        drain("R10");

        // R9: fill the whole store in store-and-forward mode
        cfg_store_fwd = 1;
        for (int i = 0; i < 2100; i++) begin
            logic [7:0] d;
            d = 8'(i * 3);
            if (i < 2048) expq.push_back({i == 0, i == 2047, i == 2047, d});
            put_byte(d, i == 0, i == 2099, i == 0, 1'b1);
            if (i == 2046) chk(rd_valid == 0, "R9 not open before last slot", rd_valid, 0);
            if (i == 2047) chk(rd_valid == 1, "R9 open at truncation", rd_valid, 1);
        end
        drain("R9 truncated frame");
        frame(70, 8'h22, 0, 1'b1, 1'b1, 1'b1);
        drain("R9 next frame");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule